// File: doc/BRIEF.md
# Grouped-Priority Level Interrupt Controller

This block collects interrupt requests for a processor core and presents the single most urgent one. There are sixteen level-sensitive external request pins and six programmable on-chip peripheral sources: three timer channels, a real-time clock, a serial port and an analog converter. There is also one debug source whose priority is fixed at the top level. The pins do not each have their own priority: pins 0 to 7 take one 4-bit value and pins 8 to 15 take another. Every peripheral has its own 4-bit value. The winning priority is compared with a 4-bit mask that the core supplies. Only a priority strictly above the mask raises the request. The block only reads the mask and never changes it.

Several sources can share one vector, so each source carries a distinct event code, a multiple of 0x20. When the core strobes `accept`, the code of the current winner is loaded into a readable event register. A separate wake output leaves standby. It is driven by pins 0 and 1, the three timers and the real-time clock, but only while the low-frequency oscillator is enabled and that source's priority beats the mask.

The control is a two-state machine. In `ST_IDLE` no request is shown. The transition `IDLE_TO_REQ` fires when some pending source beats the mask. In `ST_REQ` the request, its level and the winner's code are presented. The transition `REQ_TO_IDLE` fires once no pending source beats the mask. An accept taken in `ST_REQ` loads the event register, and an accept taken in `ST_IDLE` is ignored.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pin request is pending only while its level is held high. One clock edge after every pin above the mask drops, `irq_req` is low.
- R2: Writing address 0 sets the priority shared by pins 0–7, and writing address 1 sets the priority shared by pins 8–15.
- R3: Addresses 2 to 7 set the priorities of, in order, timer 0, timer 1, timer 2, real-time clock, serial port and converter. These are `periph_req` bits 0 to 5.
- R4: The debug source always has priority 15. Writes to addresses 8 to 15 change no priority.
- R5: A source raises `irq_req` only when its priority is strictly greater than `mask`. A priority of 0 never raises it.
- R6: Among equal winning priorities the debug source wins first. Next come the peripherals in bit order 0 to 5, then pins from index 0 upward.
- R7: On an edge where `accept` is high and `irq_req` is high, `evt_code` loads the winner's code, and it keeps that value otherwise. The codes are: debug 0x20; timer 0 0x40; timer 1 0x60; timer 2 0x80; real-time clock 0xA0; serial 0xC0; converter 0xE0; pin k 0x100 + k·0x20.
- R8: `wake` is high exactly when `lfo_en` is high and at least one of pin 0, pin 1, timer 0–2 or the real-time clock is pending with a priority strictly above `mask`.
- R9: After reset all programmable priorities are 0, and `irq_req`, `irq_level`, `wake` and `evt_code` are 0.
- R10: Outputs are registered and reflect the inputs one clock edge later. `irq_level` is the winning priority while `irq_req` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_req | input | 16 | Level-sensitive external requests |
| periph_req | input | 6 | Peripheral requests (timer0, timer1, timer2, rtc, serial, adc) |
| dbg_req | input | 1 | Debug-interface request |
| wr_en | input | 1 | Priority register write strobe |
| wr_addr | input | 4 | Priority register address |
| wr_data | input | 4 | Priority value to write |
| mask | input | 4 | Processor interrupt mask |
| lfo_en | input | 1 | Low-frequency oscillator enabled |
| accept | input | 1 | Core accepts the presented interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 4 | Priority of the presented request |
| wake | output | 1 | Wake from standby |
| evt_code | output | 12 | Event code of the last accepted source |

## Verification
The hardest cases to reach from the ports are the three-way ties. In these, a peripheral, a second peripheral and a pin sit at the same priority, or the debug source meets a peripheral programmed to 15. The bench programs the matching priorities first. It then holds the tied sources together, accepts, and removes the winner one at a time, so that each accept shows the next source in the tie order. Wake is reached by changing the mask and the oscillator enable while the same sources stay pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W = 4;
    localparam int EVT_W  = 12;
    localparam int CODE_STEP = 32;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_pkg::*;
#(
    parameter int N_GRP    = 2,
    parameter int N_PERIPH = 6,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  prio_t             wr_data,
    output prio_t             grp_prio [N_GRP],
    output prio_t             per_prio [N_PERIPH]
);
    localparam int N_REG = N_GRP + N_PERIPH;

    prio_t grp_q [N_GRP];
    prio_t per_q [N_PERIPH];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                grp_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                grp_q[g] <= wr_data;
        end
        assign grp_prio[g] = grp_q[g];
    end

    for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                per_q[p] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(N_GRP + p))
                per_q[p] <= wr_data;
        end
        assign per_prio[p] = per_q[p];
    end

    // R2
    grp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(0)) |=> grp_q[0] == $past(wr_data));

    // R4
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(N_REG)) |=>
            ($stable(grp_q[0]) && $stable(grp_q[N_GRP-1]) && $stable(per_q[0])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = 23,
    parameter logic [N_SRC-1:0] WAKE_CAP = '0
) (
    input  logic [N_SRC-1:0] src_pend,
    input  prio_t            src_prio [N_SRC],
    input  prio_t            mask,
    output logic             win_valid,
    output prio_t            win_prio,
    output logic [EVT_W-1:0] win_code,
    output logic             wake_hit
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [IDX_W-1:0] win_idx;

    always_comb begin
        win_prio = '0;
        win_idx  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src_pend[i] && src_prio[i] != '0 && src_prio[i] >= win_prio) begin
                win_prio = src_prio[i];
                win_idx  = IDX_W'(i);
            end
        end
        win_valid = win_prio > mask;
        win_code  = EVT_W'((int'(win_idx) + 1) * CODE_STEP);
    end

    always_comb begin
        wake_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (WAKE_CAP[i] && src_pend[i] && src_prio[i] > mask)
                wake_hit = 1'b1;
    end

    // R4 (source 0 is the debug source)
    dbg_top_chk: assert final (!(src_pend[0] && src_prio[0] == '1) || win_prio == '1);

    // R5
    strict_mask_chk: assert final (!win_valid || (win_prio != '0 && win_prio > mask));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int N_PIN    = 16,
    parameter int GRP_SIZE = 8,
    parameter int N_PERIPH = 6,
    parameter int ADDR_W   = 4,
    parameter logic [N_PIN-1:0]    PIN_WAKE = 16'h0003,
    parameter logic [N_PERIPH-1:0] PER_WAKE = 6'b001111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PIN-1:0]    pin_req,
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic                dbg_req,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PRIO_W-1:0]   wr_data,
    input  logic [PRIO_W-1:0]   mask,
    input  logic                lfo_en,
    input  logic                accept,
    output logic                irq_req,
    output logic [PRIO_W-1:0]   irq_level,
    output logic                wake,
    output logic [EVT_W-1:0]    evt_code
);
    localparam int N_GRP   = N_PIN / GRP_SIZE;
    localparam int PER_OFS = 1;
    localparam int PIN_OFS = PER_OFS + N_PERIPH;
    localparam int N_SRC   = PIN_OFS + N_PIN;
    localparam logic [N_SRC-1:0] WAKE_CAP = {PIN_WAKE, PER_WAKE, 1'b0};

    prio_t grp_prio [N_GRP];
    prio_t per_prio [N_PERIPH];
    prio_t src_prio [N_SRC];
    logic [N_SRC-1:0] src_pend;

    logic             win_valid;
    prio_t            win_prio;
    logic [EVT_W-1:0] win_code;
    logic             wake_hit;

    irq_state_e       state_q, state_d;
    prio_t            level_q;
    logic [EVT_W-1:0] code_q;
    logic [EVT_W-1:0] evt_q;
    logic             wake_q;

    irq_prio_regs #(
        .N_GRP   (N_GRP),
        .N_PERIPH(N_PERIPH),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .grp_prio(grp_prio),
        .per_prio(per_prio)
    );

    // Source list: debug, peripherals, pins (this order sets tie-break).
    assign src_pend[0] = dbg_req;
    assign src_prio[0] = '1;
    for (genvar p = 0; p < N_PERIPH; p++) begin : g_per_src
        assign src_pend[PER_OFS + p] = periph_req[p];
        assign src_prio[PER_OFS + p] = per_prio[p];
    end
    for (genvar k = 0; k < N_PIN; k++) begin : g_pin_src
        assign src_pend[PIN_OFS + k] = pin_req[k];
        assign src_prio[PIN_OFS + k] = grp_prio[k / GRP_SIZE];
    end

    irq_arbiter #(
        .N_SRC   (N_SRC),
        .WAKE_CAP(WAKE_CAP)
    ) u_arb (
        .src_pend (src_pend),
        .src_prio (src_prio),
        .mask     (mask),
        .win_valid(win_valid),
        .win_prio (win_prio),
        .win_code (win_code),
        .wake_hit (wake_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid)  state_d = ST_REQ;   // IDLE_TO_REQ
            ST_REQ:  if (!win_valid) state_d = ST_IDLE;  // REQ_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // State and registered data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            code_q  <= '0;
            wake_q  <= 1'b0;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            level_q <= win_valid ? win_prio : '0;
            code_q  <= win_valid ? win_code : '0;
            wake_q  <= lfo_en && wake_hit;
            if (accept && state_q == ST_REQ)
                evt_q <= code_q;
        end
    end

    // Outputs
    always_comb begin
        irq_req   = (state_q == ST_REQ);
        irq_level = level_q;
        wake      = wake_q;
        evt_code  = evt_q;
    end

    // R7
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && irq_req) |=> $stable(evt_code));

    // R8
    wake_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lfo_en |=> !wake);

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_level == '0);

    // R5
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && mask != '1) |=> (irq_req && irq_level == '1));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_req = '0;
    logic [5:0]  periph_req = '0;
    logic        dbg_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic [3:0]  mask = '0;
    logic        lfo_en = 1'b0;
    logic        accept = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic        wake;
    logic [11:0] evt_code;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .periph_req(periph_req),
        .dbg_req(dbg_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask(mask), .lfo_en(lfo_en), .accept(accept), .irq_req(irq_req),
        .irq_level(irq_level), .wake(wake), .evt_code(evt_code)
    );

    // {pin, periph, dbg, mask, lfo, exp_req, exp_level, exp_wake}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {16'h0000, 6'h00, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0}, // R10 idle
        {16'h0001, 6'h00, 1'b0, 4'd0,  1'b1, 1'b1, 4'd5,  1'b1}, // R2 R8 pin0
        {16'h0004, 6'h00, 1'b0, 4'd0,  1'b1, 1'b1, 4'd5,  1'b0}, // R2 R8 pin2 no wake
        {16'h0001, 6'h00, 1'b0, 4'd5,  1'b1, 1'b0, 4'd0,  1'b0}, // R5 equal to mask
        {16'h0100, 6'h00, 1'b0, 4'd5,  1'b1, 1'b1, 4'd9,  1'b0}, // R2 high group
        {16'h0101, 6'h08, 1'b0, 4'd4,  1'b0, 1'b1, 4'd12, 1'b0}, // R3 R8 rtc, osc off
        {16'h0101, 6'h08, 1'b0, 4'd4,  1'b1, 1'b1, 4'd12, 1'b1}, // R8 rtc, osc on
        {16'h0000, 6'h20, 1'b0, 4'd0,  1'b1, 1'b1, 4'd1,  1'b0}, // R3 adc
        {16'h0000, 6'h20, 1'b0, 4'd1,  1'b1, 1'b0, 4'd0,  1'b0}, // R5 adc masked
        {16'h0000, 6'h08, 1'b1, 4'd14, 1'b1, 1'b1, 4'd15, 1'b0}, // R4 debug
        {16'h0000, 6'h00, 1'b1, 4'd15, 1'b1, 1'b0, 4'd0,  1'b0}, // R5 debug masked
        {16'h0000, 6'h02, 1'b0, 4'd6,  1'b1, 1'b1, 4'd7,  1'b1}, // R3 R8 timer1
        {16'h0000, 6'h02, 1'b0, 4'd7,  1'b1, 1'b0, 4'd0,  1'b0}, // R5 timer1 masked
        {16'h0002, 6'h01, 1'b0, 4'd2,  1'b1, 1'b1, 4'd5,  1'b1}  // R3 R8 pin1 + timer0
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 4'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive(input logic [15:0] p, input logic [5:0] q,
                         input logic d, input logic [3:0] m, input logic l);
        @(negedge clk);
        pin_req = p; periph_req = q; dbg_req = d; mask = m; lfo_en = l;
        @(negedge clk);
    endtask

    task automatic take();
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 irq_req", int'(irq_req), 0);
        check("R9 irq_level", int'(irq_level), 0);
        check("R9 wake", int'(wake), 0);
        check("R9 evt_code", int'(evt_code), 0);
        rst_n = 1'b1;
        // R9 unprogrammed priorities stay silent
        drive(16'hFFFF, 6'h3F, 1'b0, 4'd0, 1'b1);
        check("R9 no request at prio 0", int'(irq_req), 0);
        check("R9 no wake at prio 0", int'(wake), 0);
        drive(16'h0000, 6'h00, 1'b0, 4'd0, 1'b0);

        // R2 R3 programming
        wr(0, 5); wr(1, 9);
        wr(2, 3); wr(3, 7); wr(4, 9); wr(5, 12); wr(6, 9); wr(7, 1);
        // R4 writes to unused addresses are ignored
        wr(8, 0); wr(15, 0);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            drive(v[33:18], v[17:12], v[11], v[10:7], v[6]);
            check($sformatf("R10 vec%0d irq_req", i), int'(irq_req), int'(v[5]));
            check($sformatf("R10 vec%0d irq_level", i), int'(irq_level), int'(v[4:1]));
            check($sformatf("R8 vec%0d wake", i), int'(wake), int'(v[0]));
        end

        // R4 earlier unused writes did not disturb programmed values
        drive(16'h0100, 6'h00, 1'b0, 4'd0, 1'b0);
        check("R4 high group intact", int'(irq_level), 9);
        drive(16'h0000, 6'h04, 1'b0, 4'd0, 1'b0);
        check("R4 timer2 intact", int'(irq_level), 9);

        // R1 level sensitivity
        drive(16'h0001, 6'h00, 1'b0, 4'd0, 1'b0);
        check("R1 held pin requests", int'(irq_req), 1);
        drive(16'h0000, 6'h00, 1'b0, 4'd0, 1'b0);
        check("R1 released pin clears", int'(irq_req), 0);

        // R6 R7 tie: timer2, serial, pin8 all at 9
        drive(16'h0100, 6'h14, 1'b0, 4'd0, 1'b0);
        take();
        check("R6 tie timer2 first", int'(evt_code), 'h80);
        drive(16'h0100, 6'h10, 1'b0, 4'd0, 1'b0);
        take();
        check("R6 tie serial next", int'(evt_code), 'hC0);
        drive(16'h0100, 6'h00, 1'b0, 4'd0, 1'b0);
        take();
        check("R7 pin8 code", int'(evt_code), 'h200);

        // R7 holds without accept
        drive(16'h0001, 6'h00, 1'b0, 4'd0, 1'b0);
        @(negedge clk);
        check("R7 code holds", int'(evt_code), 'h200);
        // R7 accept while idle ignored
        drive(16'h0000, 6'h00, 1'b0, 4'd0, 1'b0);
        take();
        check("R7 idle accept ignored", int'(evt_code), 'h200);

        // R6 pin tie: lowest index wins
        drive(16'h0028, 6'h00, 1'b0, 4'd0, 1'b0);
        take();
        check("R6 pin3 before pin5", int'(evt_code), 'h160);

        // R6 debug beats rtc at 15
        wr(5, 15);
        drive(16'h0000, 6'h08, 1'b1, 4'd0, 1'b0);
        take();
        check("R6 debug before rtc", int'(evt_code), 'h20);
        drive(16'h0000, 6'h08, 1'b0, 4'd0, 1'b0);
        take();
        check("R7 rtc code", int'(evt_code), 'hA0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule